// File: doc/BRIEF.md
# Bitplane Pixel Writer with One-Byte Cache

This block sits between a coordinate plotter and a byte-wide screen memory. Each accepted pixel carries X, Y and a colour. The block turns the coordinates into a byte address and a bit field. The address is a screen base plus the linear pixel index, scaled by the pixel depth. The block then inserts the colour into that field with a read-modify-write. Four pixel depths are supported, selected by a two-bit mode: 1, 2, 4 or 8 bits per pixel.

A single cached byte holds the memory byte being edited. Successive pixels that land in the same byte edit the cache in place and cause no memory traffic. A pixel that lands in a different byte first writes the cached byte back, then reads and edits the new byte. Pixels outside the configured width and height are dropped without touching memory. A flush input pushes the cached byte out and empties the cache. The plotter may send a pixel only in a cycle where the clear-to-send output is high.

The base, width, height and mode inputs are expected to stay stable while the cache holds a byte. A flush before any change of these inputs keeps them consistent.

Top module: `pixel_rmw_writer`

## Requirements
- R1: After reset the cache is empty, clear-to-send is high and neither memory strobe is active.
- R2: The byte address of an in-bounds pixel is `cfg_base + ((px_y*cfg_width + px_x) >> (3 - cfg_bpp_sel))`.
- R3: The mode `cfg_bpp_sel` encodes the pixel depth: 0 for 1 bit, 1 for 2 bits, 2 for 4 bits and 3 for 8 bits. Let P be the pixel index and N = 8/depth. Slot k = P mod N sits in bits starting at (N-1-k)*depth, so slot 0 is the most significant field. The field takes the low depth bits of `px_color`.
- R4: A pixel whose byte address equals that of the cached byte updates the cache without any memory read or write.
- R5: A pixel for a different byte while the cache is valid issues exactly one single-cycle write of the cached byte to its address, then one read of the new address. The two strobes are never active together.
- R6: A pixel arriving while the cache is empty causes one read of its byte and no write.
- R7: A pixel with `px_x >= cfg_width` or `px_y >= cfg_height` causes no memory access and leaves the cached byte unchanged.
- R8: Clear-to-send is low during every memory access and while a read is awaited. A miss into an empty cache keeps it low for 3 cycles and a miss with write-back for 4, with read data arriving 2 cycles after the read strobe.
- R9: A flush with a valid cache writes the cached byte back and empties the cache, so the next pixel to that byte reads it again. A flush with an empty cache causes no access. Clear-to-send is low while flush is high.
- R10: Bits of the byte read from memory outside the edited field are kept unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | ADDR_W | Byte address of the first screen pixel |
| cfg_width | input | COORD_W | Screen width in pixels |
| cfg_height | input | COORD_W | Screen height in lines |
| cfg_bpp_sel | input | 2 | Pixel depth select (0:1, 1:2, 2:4, 3:8 bits) |
| px_valid | input | 1 | Pixel request |
| px_x | input | COORD_W | Pixel X coordinate |
| px_y | input | COORD_W | Pixel Y coordinate |
| px_color | input | 8 | Pixel colour (low depth bits used) |
| px_cts | output | 1 | Clear-to-send: a pixel is taken this cycle if valid |
| flush | input | 1 | Write back and empty the cache |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| mem_rvalid | input | 1 | Read data valid strobe |

## Verification
A cache hit or a dropped pixel has no memory effect, and clear-to-send stays high on the next cycle. A clean miss drives the read in the cycle right after acceptance. A dirty miss drives the write in that cycle and the read in the one after. Clear-to-send returns 3 or 4 cycles after the accepting edge, and a flush write appears in the cycle after its edge. The bench counts the low clear-to-send cycles at falling edges after each acceptance and compares them with those figures. Its monitor compares each memory strobe at a falling edge, in order, against a queue that the driver fills before it presents each stimulus.

// File: rtl/pixel_rmw_writer.sv
module pixel_rmw_writer #(
  parameter int ADDR_W  = 24,
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [COORD_W-1:0] cfg_width,
  input  logic [COORD_W-1:0] cfg_height,
  input  logic [1:0]         cfg_bpp_sel,
  input  logic               px_valid,
  input  logic [COORD_W-1:0] px_x,
  input  logic [COORD_W-1:0] px_y,
  input  logic [7:0]         px_color,
  output logic               px_cts,
  input  logic               flush,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [7:0]         mem_wdata,
  input  logic [7:0]         mem_rdata,
  input  logic               mem_rvalid
);
  localparam int PIX_W = 2 * COORD_W;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_RD, S_WAIT} st_t;

  st_t               st;
  logic [ADDR_W-1:0] c_addr, p_addr;
  logic [7:0]        c_data, p_mask, p_bits;
  logic              c_valid, flushing;

  logic [PIX_W-1:0]  pix;
  logic [PIX_W-1:0]  byte_off;
  logic [3:0]        bpp;
  logic [2:0]        slot_max, lsb;
  logic [7:0]        fmask, fbits;
  logic [ADDR_W-1:0] px_addr;
  logic              in_bounds, take, hit;

  assign pix       = PIX_W'(px_y) * PIX_W'(cfg_width) + PIX_W'(px_x);
  assign bpp       = 4'd1 << cfg_bpp_sel;
  assign slot_max  = 3'd7 >> cfg_bpp_sel;
  assign lsb       = (slot_max - (pix[2:0] & slot_max)) << cfg_bpp_sel;
  assign fmask     = 8'((9'd1 << bpp) - 9'd1) << lsb;
  assign fbits     = (px_color << lsb) & fmask;
  assign byte_off  = pix >> (3'd3 - {1'b0, cfg_bpp_sel});
  assign px_addr   = cfg_base + ADDR_W'(byte_off);
  assign in_bounds = (px_x < cfg_width) && (px_y < cfg_height);

  assign px_cts    = (st == S_IDLE) && !flush;
  assign take      = px_valid && px_cts && in_bounds;
  assign hit       = c_valid && (px_addr == c_addr);

  assign mem_rd    = (st == S_RD);
  assign mem_wr    = (st == S_WB);
  assign mem_addr  = (st == S_WB) ? c_addr : p_addr;
  assign mem_wdata = c_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      c_valid  <= 1'b0;
      flushing <= 1'b0;
      c_addr   <= '0;
      c_data   <= '0;
      p_addr   <= '0;
      p_mask   <= '0;
      p_bits   <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (flush) begin
            if (c_valid) begin
              st       <= S_WB;
              flushing <= 1'b1;
            end
          end else if (take) begin
            if (hit) begin
              c_data <= (c_data & ~fmask) | fbits;
            end else begin
              p_addr   <= px_addr;
              p_mask   <= fmask;
              p_bits   <= fbits;
              flushing <= 1'b0;
              st       <= c_valid ? S_WB : S_RD;
            end
          end
        end
        S_WB: begin
          if (flushing) begin
            c_valid <= 1'b0;
            st      <= S_IDLE;
          end else begin
            st <= S_RD;
          end
        end
        S_RD: st <= S_WAIT;
        S_WAIT: begin
          if (mem_rvalid) begin
            c_data  <= (mem_rdata & ~p_mask) | p_bits;
            c_addr  <= p_addr;
            c_valid <= 1'b1;
            st      <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pixel_rmw_writer_chk.sv
module pixel_rmw_writer_chk #(
  parameter int COORD_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               px_valid,
  input logic [COORD_W-1:0] px_x,
  input logic [COORD_W-1:0] px_y,
  input logic [COORD_W-1:0] cfg_width,
  input logic [COORD_W-1:0] cfg_height,
  input logic               px_cts,
  input logic               mem_rd,
  input logic               mem_wr
);
  // R5
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R5
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);

  // R8
  cts_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    px_cts |-> (!mem_rd && !mem_wr));

  // R8
  rd_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !px_cts);

  // R7
  oob_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && px_cts && ((px_x >= cfg_width) || (px_y >= cfg_height)))
      |=> (!mem_rd && !mem_wr));
endmodule

bind pixel_rmw_writer pixel_rmw_writer_chk #(.COORD_W(COORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .px_valid(px_valid), .px_x(px_x), .px_y(px_y),
  .cfg_width(cfg_width), .cfg_height(cfg_height), .px_cts(px_cts),
  .mem_rd(mem_rd), .mem_wr(mem_wr));

// File: tb/pixel_rmw_writer_test.sv
module pixel_rmw_writer_test;
  localparam int AW = 24;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] cfg_base = 24'h001000;
  logic [CW-1:0] cfg_width = 12'd64;
  logic [CW-1:0] cfg_height = 12'd48;
  logic [1:0]    cfg_bpp_sel = 2'd0;
  logic          px_valid = 1'b0;
  logic [CW-1:0] px_x = '0, px_y = '0;
  logic [7:0]    px_color = '0;
  logic          px_cts, flush = 1'b0;
  logic          mem_rd, mem_wr;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata = '0;
  logic          mem_rvalid = 1'b0;

  always #10 clk = ~clk;

  pixel_rmw_writer #(.ADDR_W(AW), .COORD_W(CW)) uut (.*);

  int checks = 0, fails = 0, cycles = 0;

  // memory model: read data two cycles after the strobe
  logic [7:0] simmem [int];
  logic       rd_s1 = 1'b0;
  logic [AW-1:0] rd_a1 = '0;
  function automatic logic [7:0] init_byte(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction
  always @(posedge clk) begin
    mem_rvalid <= rd_s1;
    mem_rdata  <= simmem.exists(int'(rd_a1)) ? simmem[int'(rd_a1)] : init_byte(int'(rd_a1));
    rd_s1 <= mem_rd;
    rd_a1 <= mem_addr;
    if (mem_wr) simmem[int'(mem_addr)] = mem_wdata;
  end

  // scoreboard: {is_write, addr, data}
  logic [32:0] ev_q [$];
  string       tag_q [$];
  always @(negedge clk) begin
    if (rst_n && (mem_rd || mem_wr)) begin
      checks++;
      if (ev_q.size() == 0) begin
        fails++;
        $display("FAIL R4/R7/R9 unexpected access rd=%0b wr=%0b addr=%h, expected none",
                 mem_rd, mem_wr, mem_addr);
      end else begin
        logic [32:0] e;
        string t;
        e = ev_q.pop_front();
        t = tag_q.pop_front();
        if (e[32] != mem_wr || e[31:8] != mem_addr || (mem_wr && e[7:0] != mem_wdata)) begin
          fails++;
          $display("FAIL %s access wr=%0b addr=%h data=%h, expected wr=%0b addr=%h data=%h",
                   t, mem_wr, mem_addr, mem_wdata, e[32], e[31:8], e[7:0]);
        end
      end
    end
  end

  // reference model of the cache, built from the requirements
  logic [7:0] refmem [int];
  bit         rv = 0;
  logic [AW-1:0] rca = '0;
  logic [7:0] rcd = '0;

  function automatic logic [7:0] ref_get(input int a);
    return refmem.exists(a) ? refmem[a] : init_byte(a);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_pix(input int x, input int y, input int c, input string req);
    int depth, ppb, p, k, lsb, n, stall;
    logic [7:0] m, b;
    logic [AW-1:0] a;
    depth = 1 << cfg_bpp_sel;
    ppb   = 8 / depth;
    p     = y * int'(cfg_width) + x;
    k     = p % ppb;
    lsb   = (ppb - 1 - k) * depth;            // R3: slot 0 in the top bits
    m     = 8'(((1 << depth) - 1) << lsb);
    b     = 8'((c << lsb)) & m;
    a     = cfg_base + AW'(p / ppb);           // R2
    stall = 0;
    if (x >= int'(cfg_width) || y >= int'(cfg_height)) begin
      stall = 0;                               // R7
    end else if (rv && a == rca) begin
      rcd = (rcd & ~m) | b;                    // R4
    end else begin
      if (rv) begin
        ev_q.push_back({1'b1, rca, rcd}); tag_q.push_back({req, " R5 write-back"});
        refmem[int'(rca)] = rcd;
        stall = 4;
      end else stall = 3;                      // R6
      ev_q.push_back({1'b0, a, 8'h00}); tag_q.push_back({req, " R2 read"});
      rcd = (ref_get(int'(a)) & ~m) | b;       // R10
      rca = a;
      rv  = 1;
    end
    @(negedge clk);
    while (!px_cts) @(negedge clk);
    px_valid = 1'b1; px_x = CW'(x); px_y = CW'(y); px_color = 8'(c);
    @(negedge clk);
    px_valid = 1'b0;
    n = 0;
    while (!px_cts && n < 20) begin n++; @(negedge clk); end
    check(n == stall, {req, " R8 stall cycles"}, n, stall);
  endtask

  task automatic do_flush(input string req);
    if (rv) begin
      ev_q.push_back({1'b1, rca, rcd}); tag_q.push_back({req, " R9 flush write"});
      refmem[int'(rca)] = rcd;
    end
    rv = 0;
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    repeat (3) @(negedge clk);
    check(ev_q.size() == 0, {req, " R9 events drained"}, ev_q.size(), 0);
  endtask

  bit done = 0;
  initial begin
    while (!done && cycles < 20000) begin @(posedge clk); cycles++; end
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(px_cts == 1'b1, "R1 cts after reset", px_cts, 1);
    check(!mem_rd && !mem_wr, "R1 strobes idle", {mem_rd, mem_wr}, 0);

    // 1 bit per pixel
    cfg_bpp_sel = 2'd0;
    send_pix(0, 0, 1, "R6 clean miss");
    send_pix(7, 0, 1, "R4 hit");
    send_pix(3, 0, 0, "R4 hit clear");
    send_pix(8, 0, 1, "R5 dirty miss");
    send_pix(64, 0, 1, "R7 x out of range");
    send_pix(5, 48, 1, "R7 y out of range");
    send_pix(9, 0, 1, "R7 cache kept, R4 hit");
    send_pix(2, 1, 1, "R2 next line");
    do_flush("R9 dirty");
    do_flush("R9 empty");
    send_pix(3, 1, 0, "R9 reread after flush");
    do_flush("R9 before mode change");

    // 2 bits per pixel
    cfg_bpp_sel = 2'd1;
    send_pix(1, 1, 3, "R3 2bpp slot1");
    send_pix(2, 1, 2, "R3 2bpp slot2");
    send_pix(3, 1, 7, "R3 2bpp colour masked");
    do_flush("R9 2bpp");

    // 4 bits per pixel
    cfg_bpp_sel = 2'd2;
    send_pix(10, 2, 10, "R3 4bpp high nibble");
    send_pix(11, 2, 5, "R10 4bpp low nibble");
    send_pix(13, 2, 9, "R5 4bpp next byte");
    do_flush("R9 4bpp");

    // 8 bits per pixel
    cfg_bpp_sel = 2'd3;
    cfg_base = 24'h020000;
    send_pix(3, 3, 199, "R3 8bpp full byte");
    send_pix(4, 3, 17, "R5 8bpp adjacent");
    send_pix(4, 3, 34, "R4 8bpp overwrite");
    do_flush("R9 8bpp");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule